// File: doc/BRIEF.md
# Phased Shader Pass Sequencer

This block walks one pixel's shader program through a series of phases and tells three execution resources when to work. Every phase consists of a texture-fetch step followed by an arithmetic step. The number of phases is one more than the number of dependent texture reads in the program. Fetch steps go to the texture fetch unit. Arithmetic steps of every phase except the last go to the address processor. The arithmetic step of the last phase goes to the color processor.

A program descriptor is presented together with a one-cycle start strobe. The descriptor holds the dependent-read count, a fetch count for each phase and an operation count for each phase. The block issues one operation per cycle to the unit that owns the current step. Each unit is modelled inside the block as an acknowledgement returned a fixed, parameterised number of cycles after each issue. The block moves to the next step only after every acknowledgement of the current step has returned. When the last color acknowledgement is back, the block pulses done. A descriptor that breaks the limits is refused with an error pulse.

Top module: `shseq_sequencer`

## Requirements
- R1: A program with dependent-read count d (0..4) runs d+1 phases in order. Each phase issues all of its fetches before its arithmetic. No texture issue follows a color issue within one program.
- R2: Every fetch step of phase p issues exactly fetch count p operations on `tex_issue_o`. The fetch count of phase p sits in bits [3p+2:3p] of `fetch_cnt_i`.
- R3: The arithmetic step of every phase before the last issues exactly arith count p operations on `addr_issue_o`. The arith count of phase p sits in bits [4p+3:4p] of `arith_cnt_i`.
- R4: The arithmetic step of the last phase issues on `col_issue_o`. It issues its count of operations, or exactly one operation if that count is zero.
- R5: A step with a zero count takes no cycle. The next non-empty step issues in the cycle where the skipped step would have started.
- R6: A step of n operations on a unit with latency L occupies n+L+1 cycles, counted from its first issue. The next step never issues while an acknowledgement of the current one is outstanding.
- R7: A descriptor with a dependent-read count above 4 is refused. So is a descriptor where any used phase has more than 6 fetches or more than 8 operations. A refused descriptor raises `err_o` for one cycle, the cycle after start. It produces no issue, no busy and no done. Counts of unused phases are not checked.
- R8: `done_o` is high for exactly one cycle. That cycle comes one cycle after the sequencer sees the final color acknowledgement with nothing left outstanding. Counted from the start edge, this is the cycle after the sum of all step occupancies.
- R9: A start strobe while `busy_o` is high is ignored. It adds no issues and does not change the done timing.
- R10: At most one of the three issue outputs is high in any cycle, and none is high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| dep_reads_i | input | 3 | Dependent texture-read count |
| fetch_cnt_i | input | 15 | Per-phase fetch counts, 3 bits each, phase 0 lowest |
| arith_cnt_i | input | 20 | Per-phase arithmetic counts, 4 bits each, phase 0 lowest |
| tex_issue_o | output | 1 | Issue to the texture fetch unit |
| addr_issue_o | output | 1 | Issue to the address processor |
| col_issue_o | output | 1 | Issue to the color processor |
| busy_o | output | 1 | Program in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle descriptor rejection pulse |

## Verification
The bench targets programs with zero-count steps at the start, in the middle and in the final arithmetic step. A sequencer that spent a cycle on an empty step would deliver done late. A sequencer that skipped an empty final step would never touch the color processor. The bench compares done timing against the sum of per-unit latencies. A design that advanced on the last issue instead of the last acknowledgement would finish early. The limit cases are full 6/8 counts, a dependent-read count of 5, and an oversized fetch count in a used phase versus an unused one. These catch off-by-one limit checks and checks applied to the wrong phases. A second start while busy would show up as extra issues in the scoreboard.

// File: rtl/shseq_pkg.sv
package shseq_pkg;
   typedef enum logic [1:0] {
      UNIT_TEX  = 2'd0,
      UNIT_ADDR = 2'd1,
      UNIT_COL  = 2'd2
   } unit_e;
endpackage

// File: rtl/shseq_unit_ack.sv
module shseq_unit_ack #(
   parameter int LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_i,
   output logic ack_o
);
   if (LAT < 1) begin : g_bad_lat
      $error("shseq_unit_ack: LAT must be at least 1");
   end

   logic [LAT-1:0] pipe_q;

   if (LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= issue_i;
      end
   end else begin : g_many
      always_ff @(posedge clk) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[LAT-2:0], issue_i};
      end
   end

   assign ack_o = pipe_q[LAT-1];
endmodule

// File: rtl/shseq_desc_check.sv
module shseq_desc_check #(
   parameter int MAX_DEP   = 4,
   parameter int DEP_W     = 3,
   parameter int FETCH_W   = 3,
   parameter int ARITH_W   = 4,
   parameter int FETCH_LIM = 6,
   parameter int ARITH_LIM = 8
) (
   input  logic [DEP_W-1:0]               dep_i,
   input  logic [(MAX_DEP+1)*FETCH_W-1:0] fetch_i,
   input  logic [(MAX_DEP+1)*ARITH_W-1:0] arith_i,
   output logic                           ok_o
);
   localparam int NPH = MAX_DEP + 1;

   always_comb begin
      ok_o = (int'(dep_i) <= MAX_DEP);
      for (int p = 0; p < NPH; p++) begin
         if (p <= int'(dep_i)) begin
            if (int'(fetch_i[p*FETCH_W +: FETCH_W]) > FETCH_LIM) ok_o = 1'b0;
            if (int'(arith_i[p*ARITH_W +: ARITH_W]) > ARITH_LIM) ok_o = 1'b0;
         end
      end
   end
endmodule

// File: rtl/shseq_step_pick.sv
module shseq_step_pick #(
   parameter int NSTEP = 10,
   parameter int SW    = 4,
   parameter int CW    = 4
) (
   input  logic [NSTEP-1:0][CW-1:0] cnt_i,
   input  logic [SW-1:0]            from_i,
   input  logic [SW-1:0]            last_i,
   output logic [SW-1:0]            pick_o
);
   // lowest step at or after from_i, not beyond last_i, with work to do
   always_comb begin
      pick_o = last_i;
      for (int k = NSTEP - 1; k >= 0; k--) begin
         if (SW'(k) >= from_i && SW'(k) <= last_i && cnt_i[k] != '0)
            pick_o = SW'(k);
      end
   end
endmodule

// File: rtl/shseq_sequencer.sv
module shseq_sequencer #(
   parameter int MAX_DEP   = 4,
   parameter int FETCH_W   = 3,
   parameter int ARITH_W   = 4,
   parameter int FETCH_LIM = 6,
   parameter int ARITH_LIM = 8,
   parameter int LAT_TEX   = 3,
   parameter int LAT_ADDR  = 1,
   parameter int LAT_COL   = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start_i,
   input  logic [$clog2(MAX_DEP+2)-1:0]      dep_reads_i,
   input  logic [(MAX_DEP+1)*FETCH_W-1:0]    fetch_cnt_i,
   input  logic [(MAX_DEP+1)*ARITH_W-1:0]    arith_cnt_i,
   output logic                              tex_issue_o,
   output logic                              addr_issue_o,
   output logic                              col_issue_o,
   output logic                              busy_o,
   output logic                              done_o,
   output logic                              err_o
);
   import shseq_pkg::*;

   localparam int NPH   = MAX_DEP + 1;
   localparam int NSTEP = 2 * NPH;
   localparam int DEP_W = $clog2(MAX_DEP + 2);
   localparam int SW    = $clog2(NSTEP);
   localparam int CW    = (ARITH_W > FETCH_W) ? ARITH_W : FETCH_W;
   localparam int OW    = CW + 1;

   if (MAX_DEP < 1) begin : g_bad_dep
      $error("shseq_sequencer: MAX_DEP must be at least 1");
   end
   if (FETCH_LIM > (1 << FETCH_W) - 1) begin : g_bad_flim
      $error("shseq_sequencer: FETCH_LIM does not fit FETCH_W");
   end
   if (ARITH_LIM > (1 << ARITH_W) - 1) begin : g_bad_alim
      $error("shseq_sequencer: ARITH_LIM does not fit ARITH_W");
   end
   if (SW < DEP_W + 1) begin : g_bad_sw
      $error("shseq_sequencer: step index too narrow");
   end

   logic                      busy_q, done_q, err_q;
   logic [SW-1:0]             step_q;
   logic [CW-1:0]             rem_q;
   logic [OW-1:0]             out_q;
   logic [DEP_W-1:0]          dep_q;
   logic [NPH*FETCH_W-1:0]    fetch_q;
   logic [NPH*ARITH_W-1:0]    arith_q;

   // descriptor source: live inputs while idle, latched copy while running
   logic [DEP_W-1:0]          sel_dep;
   logic [NPH*FETCH_W-1:0]    sel_fetch;
   logic [NPH*ARITH_W-1:0]    sel_arith;
   assign sel_dep   = busy_q ? dep_q   : dep_reads_i;
   assign sel_fetch = busy_q ? fetch_q : fetch_cnt_i;
   assign sel_arith = busy_q ? arith_q : arith_cnt_i;

   logic [NSTEP-1:0][CW-1:0] cnt_v;
   for (genvar k = 0; k < NSTEP; k++) begin : g_step
      localparam int PH = k / 2;
      if (k % 2 == 0) begin : g_fetch
         assign cnt_v[k] = (DEP_W'(PH) <= sel_dep)
                         ? CW'(sel_fetch[PH*FETCH_W +: FETCH_W]) : '0;
      end else begin : g_arith
         logic [ARITH_W-1:0] a;
         assign a = sel_arith[PH*ARITH_W +: ARITH_W];
         assign cnt_v[k] = (DEP_W'(PH) > sel_dep)  ? '0 :
                           (DEP_W'(PH) == sel_dep) ? ((a == '0) ? CW'(1) : CW'(a)) :
                                                     CW'(a);
      end
   end

   logic desc_ok;
   shseq_desc_check #(
      .MAX_DEP(MAX_DEP), .DEP_W(DEP_W), .FETCH_W(FETCH_W), .ARITH_W(ARITH_W),
      .FETCH_LIM(FETCH_LIM), .ARITH_LIM(ARITH_LIM)
   ) u_check (
      .dep_i(dep_reads_i), .fetch_i(fetch_cnt_i), .arith_i(arith_cnt_i), .ok_o(desc_ok)
   );

   logic [SW-1:0] last_idx, from_idx, pick_idx;
   assign last_idx = SW'({sel_dep, 1'b1});
   assign from_idx = busy_q ? step_q + SW'(1) : '0;

   shseq_step_pick #(.NSTEP(NSTEP), .SW(SW), .CW(CW)) u_pick (
      .cnt_i(cnt_v), .from_i(from_idx), .last_i(last_idx), .pick_o(pick_idx)
   );

   unit_e cur_unit;
   always_comb begin
      if (!step_q[0])              cur_unit = UNIT_TEX;
      else if (step_q == last_idx) cur_unit = UNIT_COL;
      else                         cur_unit = UNIT_ADDR;
   end

   logic       issue_any, ack_any;
   logic [2:0] iss_v, ack_v;
   assign issue_any = busy_q && (rem_q != '0);
   assign iss_v[0]  = issue_any && (cur_unit == UNIT_TEX);
   assign iss_v[1]  = issue_any && (cur_unit == UNIT_ADDR);
   assign iss_v[2]  = issue_any && (cur_unit == UNIT_COL);
   assign ack_any   = |ack_v;

   for (genvar g = 0; g < 3; g++) begin : g_unit
      localparam int L = (g == 0) ? LAT_TEX : (g == 1) ? LAT_ADDR : LAT_COL;
      shseq_unit_ack #(.LAT(L)) u_ack (
         .clk(clk), .rst_n(rst_n), .issue_i(iss_v[g]), .ack_o(ack_v[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         step_q  <= '0;
         rem_q   <= '0;
         out_q   <= '0;
         dep_q   <= '0;
         fetch_q <= '0;
         arith_q <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         out_q  <= out_q + OW'(issue_any) - OW'(ack_any);
         if (!busy_q) begin
            if (start_i) begin
               if (desc_ok) begin
                  busy_q  <= 1'b1;
                  step_q  <= pick_idx;
                  rem_q   <= cnt_v[pick_idx];
                  dep_q   <= dep_reads_i;
                  fetch_q <= fetch_cnt_i;
                  arith_q <= arith_cnt_i;
               end else begin
                  err_q <= 1'b1;
               end
            end
         end else if (rem_q != '0) begin
            rem_q <= rem_q - CW'(1);
         end else if (out_q == '0) begin
            if (step_q == last_idx) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               step_q <= pick_idx;
               rem_q  <= cnt_v[pick_idx];
            end
         end
      end
   end

   assign tex_issue_o  = iss_v[0];
   assign addr_issue_o = iss_v[1];
   assign col_issue_o  = iss_v[2];
   assign busy_o       = busy_q;
   assign done_o       = done_q;
   assign err_o        = err_q;
endmodule

// File: rtl/shseq_chk.sv
module shseq_chk (
   input logic clk,
   input logic rst_n,
   input logic tex_issue_o,
   input logic addr_issue_o,
   input logic col_issue_o,
   input logic busy_o,
   input logic done_o,
   input logic err_o
);
   logic any_iss;
   assign any_iss = tex_issue_o | addr_issue_o | col_issue_o;

   assert_one_unit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tex_issue_o, addr_issue_o, col_issue_o}));

   assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !any_iss);

   assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!busy_o && !any_iss && !done_o));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   assert_ack_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !$past(any_iss));

   assert_color_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
      col_issue_o |=> !tex_issue_o);
endmodule

bind shseq_sequencer shseq_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .tex_issue_o(tex_issue_o), .addr_issue_o(addr_issue_o), .col_issue_o(col_issue_o),
   .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_shseq_sequencer.sv
module sim_shseq_sequencer;
   localparam int CLK_P = 10;
   localparam int LT = 3, LA = 1, LC = 2;

   logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
   logic [2:0]  dep_reads_i = '0;
   logic [14:0] fetch_cnt_i = '0;
   logic [19:0] arith_cnt_i = '0;
   logic tex_issue_o, addr_issue_o, col_issue_o, busy_o, done_o, err_o;

   shseq_sequencer #(.LAT_TEX(LT), .LAT_ADDR(LA), .LAT_COL(LC)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dep_reads_i(dep_reads_i),
      .fetch_cnt_i(fetch_cnt_i), .arith_cnt_i(arith_cnt_i),
      .tex_issue_o(tex_issue_o), .addr_issue_o(addr_issue_o), .col_issue_o(col_issue_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   always #(CLK_P/2) clk = ~clk;

   int checks = 0, fails = 0;
   int exp_q[$];
   int exp_done = 0;
   int cnt = 0;
   logic arm = 1'b0;
   logic mon_on = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (arm) cnt <= 0;
      else     cnt <= cnt + 1;
   end

   // monitor: pops expected unit codes (1 tex, 2 addr, 3 color)
   always @(negedge clk) begin
      if (mon_on) begin
         int code;
         int n;
         n = int'(tex_issue_o) + int'(addr_issue_o) + int'(col_issue_o);
         code = (n > 1) ? 4 : tex_issue_o ? 1 : addr_issue_o ? 2 : col_issue_o ? 3 : 0;
         if (code != 0) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9/R7 unexpected issue", code, 0);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(code == e, (e == 1) ? "R2 tex issue" : (e == 2) ? "R3 addr issue" : "R4 color issue",
                   code, e);
            end
         end
         if (done_o) begin
            chk(cnt == exp_done, "R5/R6/R8 done timing", cnt, exp_done);
            chk(exp_q.size() == 0, "R1 all steps issued before done", exp_q.size(), 0);
         end
      end
   end

   task automatic run_prog(input int dep, input int f[5], input int a[5], input bit poke);
      int sum;
      bit seen;
      sum = 0;
      for (int p = 0; p <= dep; p++) begin
         int n;
         for (int i = 0; i < f[p]; i++) exp_q.push_back(1);
         if (f[p] > 0) sum += f[p] + LT + 1;
         n = (p == dep) ? ((a[p] == 0) ? 1 : a[p]) : a[p];
         for (int i = 0; i < n; i++) exp_q.push_back((p == dep) ? 3 : 2);
         if (n > 0) sum += n + ((p == dep) ? LC : LA) + 1;
      end
      exp_done = sum;
      @(negedge clk);
      dep_reads_i = 3'(dep);
      for (int p = 0; p < 5; p++) begin
         fetch_cnt_i[p*3 +: 3] = 3'(f[p]);
         arith_cnt_i[p*4 +: 4] = 4'(a[p]);
      end
      start_i = 1'b1;
      arm = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      arm = 1'b0;
      if (poke) begin
         repeat (2) @(negedge clk);
         chk(busy_o == 1'b1, "R9 busy during run", int'(busy_o), 1);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      seen = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         if (done_o) begin
            seen = 1'b1;
            break;
         end
         @(negedge clk);
      end
      chk(seen, "R8 done reached", int'(seen), 1);
      @(negedge clk);
      chk(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
      chk(busy_o == 1'b0, "R8 idle after done", int'(busy_o), 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic run_bad(input int dep, input int f[5], input int a[5]);
      int dn;
      @(negedge clk);
      dep_reads_i = 3'(dep);
      for (int p = 0; p < 5; p++) begin
         fetch_cnt_i[p*3 +: 3] = 3'(f[p]);
         arith_cnt_i[p*4 +: 4] = 4'(a[p]);
      end
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(err_o == 1'b1, "R7 error pulse", int'(err_o), 1);
      chk(busy_o == 1'b0, "R7 no busy on reject", int'(busy_o), 0);
      @(negedge clk);
      chk(err_o == 1'b0, "R7 error one cycle", int'(err_o), 0);
      dn = 0;
      repeat (30) begin
         @(negedge clk);
         if (done_o) dn++;
      end
      chk(dn == 0, "R7 no done on reject", dn, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({tex_issue_o, addr_issue_o, col_issue_o, busy_o, done_o, err_o} == 6'b0,
          "R10 reset state", int'({tex_issue_o, addr_issue_o, col_issue_o, busy_o, done_o, err_o}), 0);
      mon_on = 1'b1;
      // single phase
      run_prog(0, '{2, 0, 0, 0, 0}, '{3, 0, 0, 0, 0}, 1'b0);
      // full five phases with skips in the middle (R5)
      run_prog(4, '{1, 0, 2, 3, 1}, '{2, 1, 0, 4, 2}, 1'b0);
      // final arithmetic count zero still issues once (R4)
      run_prog(2, '{1, 2, 1, 0, 0}, '{1, 1, 0, 0, 0}, 1'b0);
      // everything empty except forced color op; first step skipped
      run_prog(1, '{0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0}, 1'b0);
      // limits exactly at 6 fetches and 8 operations
      run_prog(1, '{6, 6, 0, 0, 0}, '{8, 8, 0, 0, 0}, 1'b0);
      // oversized count in an unused phase is accepted (R7)
      run_prog(0, '{1, 7, 7, 0, 0}, '{1, 15, 0, 0, 0}, 1'b0);
      // start while busy ignored (R9)
      run_prog(3, '{2, 1, 1, 1, 0}, '{2, 2, 1, 1, 0}, 1'b1);
      // rejected descriptors (R7)
      run_bad(5, '{1, 1, 1, 1, 1}, '{1, 1, 1, 1, 1});
      run_bad(2, '{1, 1, 7, 0, 0}, '{1, 1, 1, 0, 0});
      run_bad(1, '{1, 1, 0, 0, 0}, '{1, 9, 0, 0, 0});
      // sequencer still works after rejects
      run_prog(1, '{3, 0, 0, 0, 0}, '{0, 2, 0, 0, 0}, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule